// File: doc/BRIEF.md
# SCB Interrupt Status and Mask Controller

This block collects event flags from a command unit and a receive unit into an 8-bit status byte. It raises a level interrupt request towards the host. Each event source reports by driving a one-cycle set pulse on its own line of `evtSet`, and the flag then stays set until the host clears it. The host also writes an interrupt-control byte. That byte holds a global mask bit, a software-forced interrupt bit and four per-source mask bits, and together with the status byte it decides the interrupt level.

The host reaches three registers through a simple single-cycle register port. The interrupt-control byte is at byte offset 0. The status word is at offset 2, and its upper byte carries the status flags. A 32-bit general pointer register is at offset 4. The host acknowledges events by writing ones into the upper byte of the status word. The command byte that goes with these registers is decoded by a separate unit and is not handled here.

Top module: `scb_irq_top`

## Requirements
- R1: After reset, the control byte, the status byte, the general pointer and `irqOut` are all zero.
- R2: A one-cycle pulse on `evtSet[k]` sets status bit k at the next clock edge, for k in {7,6,5,4,3,2,0}. Bit 7 is command done, bit 6 frame received, bit 5 command unit inactive, bit 4 receive unit not ready, bit 3 management cycle done, bit 2 software event and bit 0 pause. Status bit 1 always reads 0, and a pulse on `evtSet[1]` has no effect.
- R3: A write to offset 2 clears every status bit whose position is 1 in `wrData[15:8]` and leaves the other status bits unchanged.
- R4: If a set pulse and a host clear hit the same status bit in the same cycle, the bit ends up set.
- R5: While control bit 0 (global mask) is 1, `irqOut` is 0.
- R6: While control bit 0 is 0 and control bit 1 (software interrupt) is 1, `irqOut` is 1.
- R7: Otherwise `irqOut` is 1 exactly when some status bit n in 7:4 is 1 while control bit n is 0. Status bits 3:0 never raise the interrupt.
- R8: `irqOut` is registered: it reflects the control and status bytes as they stood one clock edge earlier.
- R9: A write to offset 4 stores all 32 bits of `wrData` into the general pointer, and a read at offset 4 returns them.
- R10: `rdData` depends only on `regAddr`. Offset 0 returns the control byte in bits 7:0. Offset 2 returns the status byte in bits 15:8. Offset 4 returns the pointer. All other bits and all other offsets read 0.
- R11: A write to offset 0 stores only `wrData[7:0]` into the control byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Host write strobe, one cycle per write |
| regAddr | input | 3 | Byte offset of the register being accessed |
| wrData | input | 32 | Host write data |
| rdData | output | 32 | Read data for `regAddr` (combinational) |
| evtSet | input | 8 | One-cycle set pulses from the event sources, one per status bit |
| irqOut | output | 1 | Level interrupt request |

## Verification
Register writes and set pulses show up in `rdData` right after the clock edge that captures them. `irqOut` lags by one more edge, so it changes at the second edge after the stimulus. The bench keeps a behavioural model that steps on every rising edge and compares `irqOut` 1 ns after each edge. Explicit checks read registers half a cycle after the write edge. The interrupt checks wait one further cycle, and where the delay itself is being tested the bench checks both the old value and the new value.

// File: rtl/scb_irq_pkg.sv
package scb_irq_pkg;

  localparam int STAT_W = 8;

  // Byte offsets of the host-visible registers
  localparam int OFS_CTRL = 0;
  localparam int OFS_STAT = 2;
  localparam int OFS_PTR  = 4;

  // Status bits that can ever be set (bit 1 is unused)
  localparam logic [STAT_W-1:0] STAT_VALID = 8'hFD;

  // Control byte fields
  localparam int CTL_GMASK = 0;
  localparam int CTL_SWI   = 1;
  localparam int SRC_LO    = 4;
  localparam int SRC_HI    = 7;

  // Strobes from decode control to the datapath
  typedef struct packed {
    logic wrCtrl;
    logic wrStat;
    logic wrPtr;
    logic rdCtrl;
    logic rdStat;
    logic rdPtr;
  } scbStrobe_t;

endpackage

// File: rtl/scb_irq_ctrl.sv
module scb_irq_ctrl
  import scb_irq_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] regAddr,
  output scbStrobe_t        strobe
);

  logic hitCtrl, hitStat, hitPtr;

  always_comb begin
    hitCtrl = (regAddr == ADDR_W'(OFS_CTRL));
    hitStat = (regAddr == ADDR_W'(OFS_STAT));
    hitPtr  = (regAddr == ADDR_W'(OFS_PTR));
    strobe.wrCtrl = wrEn & hitCtrl;
    strobe.wrStat = wrEn & hitStat;
    strobe.wrPtr  = wrEn & hitPtr;
    strobe.rdCtrl = hitCtrl;
    strobe.rdStat = hitStat;
    strobe.rdPtr  = hitPtr;
  end

endmodule

// File: rtl/scb_irq_datapath.sv
module scb_irq_datapath
  import scb_irq_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  scbStrobe_t        strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic [STAT_W-1:0] evtSet,
  output logic [DATA_W-1:0] rdData,
  output logic [STAT_W-1:0] ctrlByte,
  output logic [STAT_W-1:0] statusByte,
  output logic [DATA_W-1:0] gptr,
  output logic              irqOut
);

  localparam int SRC_N = SRC_HI - SRC_LO + 1;

  logic [STAT_W-1:0] clrMask;
  logic [STAT_W-1:0] setMask;
  logic [STAT_W-1:0] statusNext;
  logic [SRC_N-1:0]  srcPending;
  logic              irqNext;

  // Per-bit status update: clear first, then set, so a set pulse wins
  genvar b;
  generate
    for (b = 0; b < STAT_W; b++) begin : g_stat
      always_comb begin
        clrMask[b]    = strobe.wrStat & wrData[STAT_W + b];
        setMask[b]    = evtSet[b] & STAT_VALID[b];
        statusNext[b] = (statusByte[b] & ~clrMask[b]) | setMask[b];
      end
    end
    for (b = 0; b < SRC_N; b++) begin : g_src
      assign srcPending[b] = statusByte[SRC_LO + b] & ~ctrlByte[SRC_LO + b];
    end
  endgenerate

  always_comb begin
    if (ctrlByte[CTL_GMASK])    irqNext = 1'b0;
    else if (ctrlByte[CTL_SWI]) irqNext = 1'b1;
    else                        irqNext = |srcPending;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlByte   <= '0;
      statusByte <= '0;
      gptr       <= '0;
      irqOut     <= 1'b0;
    end else begin
      statusByte <= statusNext;
      irqOut     <= irqNext;
      if (strobe.wrCtrl) ctrlByte <= wrData[STAT_W-1:0];
      if (strobe.wrPtr)  gptr     <= wrData;
    end
  end

  always_comb begin
    rdData = '0;
    if (strobe.rdCtrl) rdData[STAT_W-1:0] = ctrlByte;
    if (strobe.rdStat) rdData[2*STAT_W-1:STAT_W] = statusByte;
    if (strobe.rdPtr)  rdData = gptr;
  end

endmodule

// File: rtl/scb_irq_top.sv
module scb_irq_top
  import scb_irq_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic [STAT_W-1:0] evtSet,
  output logic              irqOut
);

  scbStrobe_t        strobe;
  logic [STAT_W-1:0] ctrlByte;
  logic [STAT_W-1:0] statusByte;
  logic [DATA_W-1:0] gptr;

  scb_irq_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .wrEn    (wrEn),
    .regAddr (regAddr),
    .strobe  (strobe)
  );

  scb_irq_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .wrData     (wrData),
    .evtSet     (evtSet),
    .rdData     (rdData),
    .ctrlByte   (ctrlByte),
    .statusByte (statusByte),
    .gptr       (gptr),
    .irqOut     (irqOut)
  );

endmodule

// File: rtl/scb_irq_checker.sv
module scb_irq_checker
  import scb_irq_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [DATA_W-1:0] wrData,
  input logic [STAT_W-1:0] evtSet,
  input logic              irqOut,
  input logic [STAT_W-1:0] ctrlByte,
  input logic [STAT_W-1:0] statusByte,
  input logic [DATA_W-1:0] gptr
);

  a_r2_bit1_clear: assert property (@(posedge clk) disable iff (!rstN)
    statusByte[1] == 1'b0);

  a_r2_set_pulse: assert property (@(posedge clk) disable iff (!rstN)
    ((evtSet & STAT_VALID) != '0) |=>
      ((statusByte & $past(evtSet & STAT_VALID)) == $past(evtSet & STAT_VALID)));

  a_r3_w1c: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regAddr == ADDR_W'(OFS_STAT) && evtSet == '0) |=>
      ((statusByte & $past(wrData[2*STAT_W-1:STAT_W])) == '0));

  a_r5_global_mask: assert property (@(posedge clk) disable iff (!rstN)
    ctrlByte[CTL_GMASK] |=> !irqOut);

  a_r6_soft_irq: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlByte[CTL_GMASK] && ctrlByte[CTL_SWI]) |=> irqOut);

  a_r7_no_source: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlByte[1:0] == 2'b00 && (statusByte[SRC_HI:SRC_LO] & ~ctrlByte[SRC_HI:SRC_LO]) == '0)
      |=> !irqOut);

  a_r9_ptr_store: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regAddr == ADDR_W'(OFS_PTR)) |=> (gptr == $past(wrData)));

  a_r11_ctrl_store: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regAddr == ADDR_W'(OFS_CTRL)) |=> (ctrlByte == $past(wrData[STAT_W-1:0])));

endmodule

bind scb_irq_top scb_irq_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .wrEn       (wrEn),
  .regAddr    (regAddr),
  .wrData     (wrData),
  .evtSet     (evtSet),
  .irqOut     (irqOut),
  .ctrlByte   (ctrlByte),
  .statusByte (statusByte),
  .gptr       (gptr)
);

// File: tb/scb_irq_top_bench.sv
`timescale 1ns/1ps
module scb_irq_top_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] wrData = '0;
  logic [7:0]  evtSet = '0;
  logic [31:0] rdData;
  logic        irqOut;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  // behavioural reference state
  logic [7:0]  mCtrl = '0;
  logic [7:0]  mStat = '0;
  logic [31:0] mPtr = '0;
  logic        mIrq = 1'b0;

  always #2.5 clk = ~clk;

  scb_irq_top u_scb_irq_top (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .regAddr (regAddr),
    .wrData  (wrData),
    .rdData  (rdData),
    .evtSet  (evtSet),
    .irqOut  (irqOut)
  );

  // reference model stepped on each edge, irq compared every cycle (R8)
  always @(posedge clk) begin
    logic nIrq;
    logic [7:0] clr;
    if (!rstN) begin
      mCtrl = '0; mStat = '0; mPtr = '0; mIrq = 1'b0;
    end else begin
      if (mCtrl[0])      nIrq = 1'b0;
      else if (mCtrl[1]) nIrq = 1'b1;
      else               nIrq = ((mStat[7:4] & ~mCtrl[7:4]) != 4'h0);
      clr = (wrEn && regAddr == 3'd2) ? wrData[15:8] : 8'h00;
      mStat = (mStat & ~clr) | (evtSet & 8'hFD);
      if (wrEn && regAddr == 3'd0) mCtrl = wrData[7:0];
      if (wrEn && regAddr == 3'd4) mPtr = wrData;
      mIrq = nIrq;
    end
    #1;
    if (rstN && !done) begin
      tests++;
      if (irqOut !== mIrq) begin
        fails++;
        $display("FAIL R8 per-cycle irq: actual %b expected %b at %0t", irqOut, mIrq, $time);
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic we, input logic [2:0] a, input logic [31:0] d, input logic [7:0] e);
    @(negedge clk);
    wrEn = we; regAddr = a; wrData = d; evtSet = e;
    @(negedge clk);
    wrEn = 1'b0; evtSet = '0;
  endtask

  task automatic readChk(input string tag, input logic [2:0] a, input logic [31:0] exp);
    regAddr = a;
    #1;
    check(tag, rdData, exp);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    idle(3);
    // R1 reset values
    readChk("R1 ctrl", 3'd0, 32'h0);
    readChk("R1 status", 3'd2, 32'h0);
    readChk("R1 ptr", 3'd4, 32'h0);
    check("R1 irq", {31'h0, irqOut}, 32'h0);
    rstN = 1'b1;
    idle(2);

    // R9 pointer
    drive(1'b1, 3'd4, 32'hDEAD_BEEF, 8'h00);
    readChk("R9 ptr", 3'd4, 32'hDEAD_BEEF);
    // R10 unmapped offsets read zero
    readChk("R10 unmapped 6", 3'd6, 32'h0);
    readChk("R10 unmapped 1", 3'd1, 32'h0);

    // R2 set pulses, bit 1 ignored; R8 irq one edge later
    drive(1'b0, 3'd2, 32'h0, 8'hFF);
    readChk("R2 status all", 3'd2, 32'h0000_FD00);
    check("R8 irq not yet", {31'h0, irqOut}, 32'h0);
    @(negedge clk);
    check("R8 irq raised", {31'h0, irqOut}, 32'h1);

    // R5 global mask
    drive(1'b1, 3'd0, 32'h0000_0001, 8'h00);
    @(negedge clk);
    check("R5 masked", {31'h0, irqOut}, 32'h0);
    readChk("R10 ctrl read", 3'd0, 32'h0000_0001);

    // R7 all sources masked, low status bits still set
    drive(1'b1, 3'd0, 32'h0000_00F0, 8'h00);
    @(negedge clk);
    check("R7 sources masked", {31'h0, irqOut}, 32'h0);
    drive(1'b1, 3'd0, 32'h0000_0070, 8'h00);
    @(negedge clk);
    check("R7 bit7 unmasked", {31'h0, irqOut}, 32'h1);

    // R3 acknowledge bit 7
    drive(1'b1, 3'd2, 32'h0000_8000, 8'h00);
    readChk("R3 w1c", 3'd2, 32'h0000_7D00);
    @(negedge clk);
    check("R3 irq dropped", {31'h0, irqOut}, 32'h0);

    // R6 software interrupt, then R5 overrides it
    drive(1'b1, 3'd0, 32'h0000_00F2, 8'h00);
    @(negedge clk);
    check("R6 swi", {31'h0, irqOut}, 32'h1);
    drive(1'b1, 3'd0, 32'h0000_00F3, 8'h00);
    @(negedge clk);
    check("R5 over swi", {31'h0, irqOut}, 32'h0);

    // R4 set beats clear in the same cycle
    drive(1'b1, 3'd2, 32'h0000_FF00, 8'h40);
    readChk("R4 set wins", 3'd2, 32'h0000_4000);

    // R2 bit 1 pulse alone changes nothing
    drive(1'b0, 3'd0, 32'h0, 8'h02);
    readChk("R2 bit1 ignored", 3'd2, 32'h0000_4000);

    // R11 only low byte of control stored
    drive(1'b1, 3'd0, 32'hFFFF_FF00, 8'h00);
    readChk("R11 ctrl low byte", 3'd0, 32'h0);
    @(negedge clk);
    check("R7 bit6 pending", {31'h0, irqOut}, 32'h1);

    // R3 clear leaves other bits; model cross-check
    drive(1'b1, 3'd2, 32'h0000_4000, 8'h00);
    readChk("R3 cleared bit6", 3'd2, {16'h0, mStat, 8'h0});
    readChk("R9 ptr kept", 3'd4, mPtr);
    idle(3);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule